// File: doc/BRIEF.md
# Watchdog Timer with Stretched Reset Outputs

This block is an 8-bit up-counting watchdog. Software programs a control register (operating-mode bit, enable bit and a 3-bit prescale select), a counter register and a reset-control register through a small synchronous register port. Once the block is in watchdog mode and enabled, the counter advances on each prescaled tick. Software must rewrite the counter to zero often enough to keep it from passing 0xFF.

When the counter wraps from 0xFF to 0x00, the block sets a sticky overflow flag. It also raises an external overflow output for 64 clock cycles. If the reset-enable bit is set, it additionally raises an internal reset output for 128 cycles, tagged as a power-on or a manual reset. A power-on internal reset returns every register to its default value. A manual one keeps the overflow flag so software can see why the reset happened. The active-low reset input takes priority over everything and clears the flag.

Top module: `wdog_rst_top`

## Requirements
- R1: After the reset input is released, every register reads 0x00 and all three outputs are low. Register map (addr_i): 0 = control (bit 7 mode, 1 = watchdog; bit 5 enable; bits 2:0 prescale select), 1 = counter, 2 = reset control (bit 7 overflow flag, bit 6 reset enable, bit 5 reset type, 1 = manual), 3 reads 0. Unused bits read 0.
- R2: The counter advances only while both the mode bit and the enable bit are 1, and otherwise holds its value. A control write that changes the enable bit from 1 to 0 clears the counter and the prescaler.
- R3: Prescale select values 0 to 7 give one tick every 1, 4, 16, 32, 64, 256, 1024 and 4096 clocks. N clock edges after the enabling write, the counter holds floor(N / ratio) more than its loaded value.
- R4: The counter steps by one on each tick. A tick at 0xFF wraps it to 0x00, and this wrap is the overflow.
- R5: A counter write in the same cycle as a tick loads the written value and drops the tick, so no overflow comes from it. Periodic rewrites to 0x00 prevent any overflow.
- R6: An overflow sets the overflow flag in the cycle after the wrap edge. A software write of 1 never sets the flag.
- R7: The flag clears only on a reset-control write with bit 7 = 0 that follows a read of that register which returned the flag as 1. A write of 0 without such a read leaves the flag at 1.
- R8: ovf_pulse_o rises in the cycle after the wrap edge and stays high for exactly 64 cycles.
- R9: If reset enable is 1 at the overflow, int_rst_o rises together with ovf_pulse_o and stays high for exactly 128 cycles. If reset enable is 0, int_rst_o stays low.
- R10: While int_rst_o is high, int_rst_manual_o shows the reset type that was selected at the overflow and does not change.
- R11: While int_rst_o is high, register writes are ignored and all fields return to 0. The overflow flag is kept when the type is manual and cleared when it is power-on.
- R12: Asserting rst_ni clears the counter, the flag and both pulse outputs, even on the edge where an overflow would have happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | External reset, active low, asynchronous, highest priority |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (arms the flag clear) |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| ovf_pulse_o | output | 1 | External overflow pulse, 64 cycles |
| int_rst_o | output | 1 | Internal reset pulse, 128 cycles |
| int_rst_manual_o | output | 1 | 1 = internal reset is manual type, 0 = power-on |

## Verification
The hardest case to reach is a counter write that lands on the same edge as a tick at 0xFF. With a slow prescaler this coincidence is very rare. The bench therefore selects the divide-by-1 ratio, where every running cycle is a tick. It then writes 0xFF and 0x00 on back-to-back edges, so the second write must win over the wrap. The external-reset priority case is reached the same way. The counter is preloaded to 0xFD at divide-by-1, which puts the wrap on a known edge, and rst_ni is pulled low just before that edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int DATA_W = 8;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_COUNT = 2'd1;
    localparam logic [1:0] ADDR_RSTC  = 2'd2;

    localparam int CTRL_MODE_BIT = 7;
    localparam int CTRL_EN_BIT   = 5;
    localparam int RSTC_FLAG_BIT = 7;
    localparam int RSTC_EN_BIT   = 6;
    localparam int RSTC_SEL_BIT  = 5;

    typedef struct packed {
        logic              mode;
        logic              en;
        logic [2:0]        clksel;
        logic [DATA_W-1:0] count;
        logic              flag;
        logic              armed;
        logic              rst_en;
        logic              rst_sel;
    } wdog_regs_t;

    // log2 of the prescale ratio for each select code
    function automatic logic [3:0] sel_shift(input logic [2:0] sel);
        logic [3:0] sh;
        case (sel)
            3'd0:    sh = 4'd0;
            3'd1:    sh = 4'd2;
            3'd2:    sh = 4'd4;
            3'd3:    sh = 4'd5;
            3'd4:    sh = 4'd6;
            3'd5:    sh = 4'd8;
            3'd6:    sh = 4'd10;
            default: sh = 4'd12;
        endcase
        return sh;
    endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       run_i,
    input  logic [2:0] clksel_i,
    output logic       tick_o
);
    import wdog_pkg::*;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask   = (PRE_W'(1) << sel_shift(clksel_i)) - PRE_W'(1);
        tick_o = run_i && ((pre_q & mask) == mask);
        pre_d  = run_i ? pre_q + PRE_W'(1) : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_d;
    end
endmodule

// File: rtl/wdog_stretch.sv
module wdog_stretch #(
    parameter int LEN = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_i,
    output logic active_o
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (trig_i)            cnt_d = CW'(LEN);
        else if (cnt_q != '0)  cnt_d = cnt_q - CW'(1);
        else                   cnt_d = '0;
        active_o = (cnt_q != '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              tick_i,
    input  logic              irst_active_i,
    input  logic              irst_manual_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              run_o,
    output logic [2:0]        clksel_o,
    output logic              ovf_evt_o,
    output logic              cnt_wr_o,
    output logic [DATA_W-1:0] count_o,
    output logic              flag_o,
    output logic              rst_en_o,
    output logic              rst_sel_o
);
    wdog_regs_t r_d, r_q;
    logic wr_ctrl, wr_rstc;

    always_comb begin
        r_d       = r_q;
        ovf_evt_o = 1'b0;
        wr_ctrl   = wr_en_i && (addr_i == ADDR_CTRL)  && !irst_active_i;
        cnt_wr_o  = wr_en_i && (addr_i == ADDR_COUNT) && !irst_active_i;
        wr_rstc   = wr_en_i && (addr_i == ADDR_RSTC)  && !irst_active_i;
        run_o     = r_q.mode && r_q.en;

        // counting; a write in the same cycle wins over the tick
        if (cnt_wr_o) begin
            r_d.count = wdata_i;
        end else if (run_o && tick_i) begin
            if (r_q.count == '1) begin
                r_d.count = '0;
                ovf_evt_o = 1'b1;
            end else begin
                r_d.count = r_q.count + DATA_W'(1);
            end
        end

        if (wr_ctrl) begin
            r_d.mode   = wdata_i[CTRL_MODE_BIT];
            r_d.en     = wdata_i[CTRL_EN_BIT];
            r_d.clksel = wdata_i[2:0];
            if (r_q.en && !wdata_i[CTRL_EN_BIT]) r_d.count = '0;
        end

        // read of the flag as 1 arms the clear
        if (rd_en_i && (addr_i == ADDR_RSTC) && r_q.flag) r_d.armed = 1'b1;

        if (wr_rstc) begin
            r_d.rst_en  = wdata_i[RSTC_EN_BIT];
            r_d.rst_sel = wdata_i[RSTC_SEL_BIT];
            if (!wdata_i[RSTC_FLAG_BIT] && r_q.armed) begin
                r_d.flag  = 1'b0;
                r_d.armed = 1'b0;
            end
        end

        if (ovf_evt_o) r_d.flag = 1'b1;

        // internal reset: defaults, flag survives a manual reset
        if (irst_active_i) begin
            r_d.mode    = 1'b0;
            r_d.en      = 1'b0;
            r_d.clksel  = '0;
            r_d.count   = '0;
            r_d.rst_en  = 1'b0;
            r_d.rst_sel = 1'b0;
            if (!irst_manual_i) begin
                r_d.flag  = 1'b0;
                r_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_CTRL: begin
                rdata_o[CTRL_MODE_BIT] = r_q.mode;
                rdata_o[CTRL_EN_BIT]   = r_q.en;
                rdata_o[2:0]           = r_q.clksel;
            end
            ADDR_COUNT: rdata_o = r_q.count;
            ADDR_RSTC: begin
                rdata_o[RSTC_FLAG_BIT] = r_q.flag;
                rdata_o[RSTC_EN_BIT]   = r_q.rst_en;
                rdata_o[RSTC_SEL_BIT]  = r_q.rst_sel;
            end
            default: rdata_o = '0;
        endcase
        clksel_o  = r_q.clksel;
        count_o   = r_q.count;
        flag_o    = r_q.flag;
        rst_en_o  = r_q.rst_en;
        rst_sel_o = r_q.rst_sel;
    end
endmodule

// File: rtl/wdog_rst_top.sv
module wdog_rst_top #(
    parameter int PRE_W    = 12,
    parameter int OVF_LEN  = 64,
    parameter int IRST_LEN = 128
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_en_i,
    input  logic       rd_en_i,
    input  logic [1:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       ovf_pulse_o,
    output logic       int_rst_o,
    output logic       int_rst_manual_o
);
    logic       run, tick, ovf_evt, cnt_wr, flag, rst_en, rst_sel;
    logic [2:0] clksel;
    logic [7:0] count;
    logic       irst_trig;
    logic       type_d, type_q;

    wdog_prescaler #(.PRE_W(PRE_W)) i_pre (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run),
        .clksel_i(clksel), .tick_o(tick)
    );

    wdog_regfile i_regs (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .tick_i(tick),
        .irst_active_i(int_rst_o), .irst_manual_i(type_q),
        .rdata_o(rdata_o), .run_o(run), .clksel_o(clksel),
        .ovf_evt_o(ovf_evt), .cnt_wr_o(cnt_wr), .count_o(count),
        .flag_o(flag), .rst_en_o(rst_en), .rst_sel_o(rst_sel)
    );

    always_comb begin
        irst_trig = ovf_evt && rst_en;
        type_d    = irst_trig ? rst_sel : type_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) type_q <= 1'b0;
        else         type_q <= type_d;
    end

    wdog_stretch #(.LEN(OVF_LEN)) i_ovf_str (
        .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(ovf_evt), .active_o(ovf_pulse_o)
    );

    wdog_stretch #(.LEN(IRST_LEN)) i_irst_str (
        .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(irst_trig), .active_o(int_rst_o)
    );

    assign int_rst_manual_o = int_rst_o && type_q;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       wr_en_i,
    input logic       run,
    input logic       ovf_evt,
    input logic       cnt_wr,
    input logic [7:0] count,
    input logic       flag,
    input logic       rst_en,
    input logic       ovf_pulse_o,
    input logic       int_rst_o,
    input logic       int_rst_manual_o
);
    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run && !wr_en_i && !int_rst_o) |=> $stable(count)); // R2
    AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_wr |-> !ovf_evt); // R5
    AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_evt |=> flag); // R6
    AST_OVF_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_evt |=> ovf_pulse_o); // R8
    AST_IRST_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(int_rst_o) |-> ($past(rst_en) && ovf_pulse_o)); // R9
    AST_TYPE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int_rst_o && $past(int_rst_o)) |-> $stable(int_rst_manual_o)); // R10
endmodule

bind wdog_rst_top wdog_chk i_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .run(run),
    .ovf_evt(ovf_evt), .cnt_wr(cnt_wr), .count(count), .flag(flag),
    .rst_en(rst_en), .ovf_pulse_o(ovf_pulse_o), .int_rst_o(int_rst_o),
    .int_rst_manual_o(int_rst_manual_o)
);

// File: tb/test_wdog_rst_top.sv
module test_wdog_rst_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       ovf_o, irst_o, irst_man_o;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    wdog_rst_top i_wdog_rst_top (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .ovf_pulse_o(ovf_o), .int_rst_o(irst_o), .int_rst_manual_o(irst_man_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_arm(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        addr = a; #0.5 d = rdata;
    endtask

    task automatic count_high(input int n, input bit which, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            if (which ? irst_o : ovf_o) hi++;
            @(posedge clk); #1;
        end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            peek(2'(a), v);
            check("R1 register default", v, 0);
        end
        check("R1 ovf low", ovf_o, 0);
        check("R1 irst low", irst_o, 0);
        check("R1 type low", irst_man_o, 0);
    endtask

    task automatic t_gating;
        logic [7:0] v;
        wr(2'd1, 8'd5);
        wr(2'd0, 8'h80);
        repeat (20) @(posedge clk); #1;
        peek(2'd1, v); check("R2 mode only holds", v, 5);
        wr(2'd0, 8'h20);
        repeat (20) @(posedge clk); #1;
        peek(2'd1, v); check("R2 enable only holds", v, 5);
        wr(2'd0, 8'hA0);
        repeat (3) @(posedge clk); #1;
        peek(2'd1, v); check("R4 counts by one", v, 8);
        wr(2'd0, 8'h00);
        peek(2'd1, v); check("R2 disable clears", v, 0);
    endtask

    task automatic t_ratio(input logic [2:0] sel, input int ratio, input int n);
        logic [7:0] v;
        wr(2'd1, 8'd0);
        wr(2'd0, 8'hA0 | {5'd0, sel});
        repeat (n) @(posedge clk); #1;
        peek(2'd1, v);
        check($sformatf("R3 ratio %0d", ratio), v, n / ratio);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_overflow_flag;
        logic [7:0] v;
        int hi;
        wr(2'd2, 8'h00);
        wr(2'd1, 8'hFD);
        wr(2'd0, 8'hA0);
        repeat (2) @(posedge clk); #1;
        check("R8 no pulse before wrap", ovf_o, 0);
        @(posedge clk); #1;
        peek(2'd1, v); check("R4 wrap to zero", v, 0);
        peek(2'd2, v); check("R6 flag set", v, 8'h80);
        count_high(200, 1'b0, hi);
        check("R8 ovf pulse length", hi, 64);
        check("R9 no irst when disabled", irst_o, 0);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h80);
        peek(2'd2, v); check("R6 write 1 keeps flag", v, 8'h80);
        wr(2'd2, 8'h00);
        peek(2'd2, v); check("R7 clear needs read", v, 8'h80);
        rd_arm(2'd2, v); check("R7 read sees flag", v, 8'h80);
        wr(2'd2, 8'h00);
        peek(2'd2, v); check("R7 cleared after read", v, 0);
        wr(2'd2, 8'h80);
        peek(2'd2, v); check("R6 write 1 never sets", v, 0);
    endtask

    task automatic t_irst(input bit manual);
        logic [7:0] v;
        int hi, ohi;
        wr(2'd2, manual ? 8'h60 : 8'h40);
        wr(2'd1, 8'hFD);
        wr(2'd0, 8'hA0);
        repeat (3) @(posedge clk); #1;
        check("R9 irst with ovf", irst_o, 1);
        check("R10 type output", irst_man_o, manual);
        wr(2'd0, 8'hA1);
        peek(2'd0, v); check("R11 write ignored", v, 0);
        hi = 1; ohi = 1;
        for (int i = 0; i < 200; i++) begin
            if (irst_o) hi++;
            if (ovf_o) ohi++;
            if (irst_o) check("R10 type steady", irst_man_o, manual);
            @(posedge clk); #1;
        end
        check("R9 irst length", hi, 128);
        check("R8 ovf length with irst", ohi, 64);
        peek(2'd2, v);
        check(manual ? "R11 manual keeps flag" : "R11 power-on clears flag", v, manual ? 8'h80 : 8'h00);
        peek(2'd0, v); check("R11 ctrl default", v, 0);
        if (manual) begin
            rd_arm(2'd2, v);
            wr(2'd2, 8'h00);
        end
    endtask

    task automatic t_collision;
        logic [7:0] v;
        int hi;
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hA0);
        wr(2'd1, 8'hFF);
        peek(2'd1, v); check("R5 write loads over tick", v, 8'hFF);
        wr(2'd1, 8'h00);
        peek(2'd1, v); check("R5 write wins at FF", v, 0);
        check("R5 no ovf pulse", ovf_o, 0);
        hi = 0;
        for (int k = 0; k < 5; k++) begin
            for (int i = 0; i < 200; i++) begin
                if (ovf_o) hi++;
                @(posedge clk); #1;
            end
            wr(2'd1, 8'h00);
        end
        check("R5 periodic reload prevents ovf", hi, 0);
        peek(2'd2, v); check("R5 flag still clear", v, 0);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_ext_reset;
        logic [7:0] v;
        wr(2'd2, 8'h40);
        wr(2'd1, 8'hFD);
        wr(2'd0, 8'hA0);
        repeat (2) @(posedge clk); #1;
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R12 no ovf under pin reset", ovf_o, 0);
        check("R12 no irst under pin reset", irst_o, 0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        peek(2'd2, v); check("R12 flag cleared", v, 0);
        peek(2'd1, v); check("R12 counter cleared", v, 0);
        repeat (5) @(posedge clk); #1;
        check("R12 stays quiet", ovf_o, 0);
    endtask

    initial begin
        #200000;
        bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_gating();
        t_ratio(3'd0, 1, 10);
        t_ratio(3'd1, 4, 40);
        t_ratio(3'd2, 16, 64);
        t_ratio(3'd4, 64, 256);
        t_ratio(3'd7, 4096, 8192);
        t_overflow_flag();
        t_irst(1'b1);
        t_irst(1'b0);
        t_collision();
        t_ext_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule